// File: doc/BRIEF.md
# Saturating Up/Down Wiper Position Controller

This block holds the digital position of a 128-tap resistor-string potentiometer. Three slow control lines steer it: an active-low select, a count strobe and a direction line. They are usually driven by debounced push buttons or by other logic running at a slower rate. The block samples all three with a fast system clock. Each falling edge of the count strobe, taken while select is low, moves the 7-bit wiper code by one step.

The code starts at midscale after reset. It stops at either end of travel and never wraps. It is shown in two forms: as a binary value, and as a one-hot vector that closes exactly one switch of the resistor-string array. A one-cycle pulse marks every cycle in which the position really moved.

Top module: `wiper_pos_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, `code` is 7'h40, only bit 64 of `tapSel` is set, and `stepPulse` is 0.
- R2: A falling edge of `cntClk` taken while `csN` is 0 and `upDn` is 1 raises `code` by exactly one. The new code appears three system clock edges after the strobe falls.
- R3: A falling edge of `cntClk` taken while `csN` is 0 and `upDn` is 0 lowers `code` by exactly one.
- R4: With `code` at 7'h7F, an upward edge leaves `code` at 7'h7F and gives no `stepPulse`.
- R5: With `code` at 7'h00, a downward edge leaves `code` at 7'h00 and gives no `stepPulse`.
- R6: While `csN` is 1, no activity on `cntClk` or `upDn` changes `code`.
- R7: `tapSel` always has exactly one bit set, and that bit is the one whose index equals `code`, in the same cycle.
- R8: `stepPulse` is 1 for exactly one cycle in each cycle where `code` differs from its previous value, and is 0 in every other cycle.
- R9: Each falling edge gives at most one step, however long `cntClk` stays low. Rising edges of `cntClk` never change `code`.
- R10: `csN` and `upDn` pass through the same synchronizer depth as `cntClk`. If one of them changes in the same system cycle as the strobe falls, its new value decides the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the control lines |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select; while it is high, steps are blocked |
| cntClk | input | 1 | Count strobe; its falling edge requests one step |
| upDn | input | 1 | Direction: 1 steps up, 0 steps down |
| code | output | 7 | Current wiper code |
| tapSel | output | 128 | One-hot tap select for the switch array |
| stepPulse | output | 1 | One-cycle pulse when the code changed |

## Verification
Two events can land in the same cycle: a detected strobe edge, and a change of select or direction. Both cases are provoked by moving `csN` or `upDn` on the same system clock cycle as the strobe falls. The bench then expects the new level to rule: the step is blocked when select was raised, and it goes the new way when direction flipped.

Step requests that arrive at either end of travel are judged by two conditions. The code must stay put, and no `stepPulse` may be counted. Every change of the code must also be matched by exactly one pulse.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } stepCtl_t;
endpackage

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     csN,
  input  logic     cntClk,
  input  logic     upDn,
  output stepCtl_t stepCtl
);
  // bit 2 = select, bit 1 = strobe, bit 0 = direction
  localparam int LINES = 3;
  localparam logic [LINES-1:0] SYNC_RST = 3'b100;

  logic [LINES-1:0] rawIn;
  logic [LINES-1:0] syncQ [SYNC_STAGES];
  logic [LINES-1:0] syncOut;
  logic             prevClk;
  logic             fallSeen;
  logic             selActive;

  assign rawIn = {csN, cntClk, upDn};

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[0] <= SYNC_RST;
        else       syncQ[0] <= rawIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= SYNC_RST;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  end

  assign syncOut = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevClk <= 1'b0;
    else       prevClk <= syncOut[1];
  end

  assign fallSeen  = prevClk & ~syncOut[1];
  assign selActive = ~syncOut[2];

  always_comb begin
    stepCtl.stepUp   = fallSeen & selActive & syncOut[0];
    stepCtl.stepDown = fallSeen & selActive & ~syncOut[0];
  end
endmodule

// File: rtl/wiper_datapath.sv
module wiper_datapath
  import wiper_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCtl_t          stepCtl,
  output logic [CODE_W-1:0] code,
  output logic [(1<<CODE_W)-1:0] tapSel,
  output logic              stepPulse
);
  localparam int TAPS = 1 << CODE_W;
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(TAPS / 2);
  localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(TAPS - 1);
  localparam logic [CODE_W-1:0] CODE_MIN = '0;

  logic canUp;
  logic canDown;

  assign canUp   = stepCtl.stepUp   && (code != CODE_MAX);
  assign canDown = stepCtl.stepDown && (code != CODE_MIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      code      <= CODE_MID;
      stepPulse <= 1'b0;
    end else begin
      stepPulse <= canUp | canDown;
      if (canUp)        code <= code + 1'b1;
      else if (canDown) code <= code - 1'b1;
    end
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign tapSel[t] = (code == CODE_W'(t));
  end
endmodule

// File: rtl/wiper_pos_ctrl.sv
module wiper_pos_ctrl
  import wiper_pkg::*;
#(
  parameter int CODE_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   csN,
  input  logic                   cntClk,
  input  logic                   upDn,
  output logic [CODE_W-1:0]      code,
  output logic [(1<<CODE_W)-1:0] tapSel,
  output logic                   stepPulse
);
  stepCtl_t stepCtl;

  wiper_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .cntClk(cntClk), .upDn(upDn),
    .stepCtl(stepCtl)
  );

  wiper_datapath #(.CODE_W(CODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stepCtl(stepCtl),
    .code(code), .tapSel(tapSel), .stepPulse(stepPulse)
  );
endmodule

// File: rtl/wiper_pos_chk.sv
module wiper_pos_chk #(
  parameter int CODE_W = 7
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   csN,
  input logic [CODE_W-1:0]      code,
  input logic [(1<<CODE_W)-1:0] tapSel,
  input logic                   stepPulse
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1 << (CODE_W-1));
  localparam logic [CODE_W-1:0] TOP = '1;

  // R1: midscale held through reset
  a_r1_reset_mid: assert property (@(posedge clk) !rstN |=> (code == MID) && !stepPulse);

  // R2 / R3: moves are single steps
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (code != $past(code)) |->
      ((code == CODE_W'($past(code) + 1'b1)) || (code == CODE_W'($past(code) - 1'b1))));

  // R4 / R5: no wrap at either end
  a_r4_no_wrap_top: assert property (@(posedge clk) disable iff (!rstN)
    ($past(code) == TOP) |-> (code != '0));
  a_r5_no_wrap_bottom: assert property (@(posedge clk) disable iff (!rstN)
    ($past(code) == '0) |-> (code != TOP));

  // R6: select held high blocks every step
  a_r6_cs_hold: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> $stable(code));

  // R7: tap vector is one-hot on the code
  a_r7_onehot: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(tapSel) == 1) && tapSel[code]);

  // R8: pulse exactly on a change
  a_r8_pulse_match: assert property (@(posedge clk) disable iff (!rstN)
    stepPulse == (code != $past(code)));
endmodule

bind wiper_pos_ctrl wiper_pos_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .code(code),
  .tapSel(tapSel), .stepPulse(stepPulse)
);

// File: tb/test_wiper_pos_ctrl.sv
module test_wiper_pos_ctrl;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         csN = 1'b1;
  logic         cntClk = 1'b1;
  logic         upDn = 1'b1;
  logic [6:0]   code;
  logic [127:0] tapSel;
  logic         stepPulse;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  int expCode = 64;
  bit done = 0;

  always #4 clk = ~clk;

  wiper_pos_ctrl i_wiper_pos_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .cntClk(cntClk), .upDn(upDn),
    .code(code), .tapSel(tapSel), .stepPulse(stepPulse)
  );

  always @(negedge clk) if (rstN && stepPulse) pulses++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkPos(input string req);
    logic [127:0] expTap;
    expTap = 128'd1 << expCode;
    check(code == 7'(expCode), req, int'(code), expCode);
    check(tapSel == expTap, {req, " R7 tap"}, $clog2(tapSel + 128'd0), expCode);
  endtask

  // one strobe period: low for 5 cycles, high for 5
  task automatic strobe(input bit dir);
    @(negedge clk) upDn = dir;
    @(negedge clk) cntClk = 1'b0;
    repeat (5) @(negedge clk);
    cntClk = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic stepModel(input bit dir);
    if (dir && expCode < 127) expCode++;
    else if (!dir && expCode > 0) expCode--;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checkPos("R1 reset");
    check(stepPulse == 1'b0, "R1 pulse", int'(stepPulse), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkPos("R1 after reset");
    csN = 1'b0;
    repeat (3) @(negedge clk);

    // R2 / R8: climb to the top
    for (int i = 0; i < 63; i++) begin
      p0 = pulses;
      strobe(1'b1);
      stepModel(1'b1);
      checkPos("R2 up");
      check(pulses - p0 == 1, "R8 pulse on up", pulses - p0, 1);
    end
    // R4: saturate at 7Fh
    for (int i = 0; i < 3; i++) begin
      p0 = pulses;
      strobe(1'b1);
      checkPos("R4 top hold");
      check(pulses == p0, "R4 no pulse", pulses - p0, 0);
    end
    // R3: full sweep down
    for (int i = 0; i < 127; i++) begin
      p0 = pulses;
      strobe(1'b0);
      stepModel(1'b0);
      checkPos("R3 down");
      check(pulses - p0 == 1, "R8 pulse on down", pulses - p0, 1);
    end
    // R5: saturate at 00h
    for (int i = 0; i < 3; i++) begin
      p0 = pulses;
      strobe(1'b0);
      checkPos("R5 bottom hold");
      check(pulses == p0, "R5 no pulse", pulses - p0, 0);
    end
    // move off the end
    for (int i = 0; i < 5; i++) begin strobe(1'b1); stepModel(1'b1); end
    checkPos("R2 off bottom");

    // R6: select high blocks both directions
    @(negedge clk) csN = 1'b1;
    repeat (3) @(negedge clk);
    p0 = pulses;
    for (int i = 0; i < 4; i++) begin strobe(1'b1); strobe(1'b0); end
    checkPos("R6 cs high");
    check(pulses == p0, "R6 no pulse", pulses - p0, 0);
    @(negedge clk) csN = 1'b0;
    repeat (3) @(negedge clk);

    // R9: long low phase gives one step; rising edge gives none
    p0 = pulses;
    @(negedge clk) upDn = 1'b1;
    @(negedge clk) cntClk = 1'b0;
    repeat (50) @(negedge clk);
    stepModel(1'b1);
    checkPos("R9 long low");
    cntClk = 1'b1;
    repeat (10) @(negedge clk);
    checkPos("R9 rising edge");
    check(pulses - p0 == 1, "R9 single pulse", pulses - p0, 1);

    // R10: select rises with the strobe fall -> ignored
    @(negedge clk) begin csN = 1'b1; cntClk = 1'b0; end
    repeat (6) @(negedge clk);
    checkPos("R10 cs with edge");
    cntClk = 1'b1;
    csN = 1'b0;
    repeat (6) @(negedge clk);
    // R10: direction flips with the strobe fall -> new direction used
    @(negedge clk) begin upDn = 1'b0; cntClk = 1'b0; end
    repeat (6) @(negedge clk);
    stepModel(1'b0);
    checkPos("R10 dir with edge");
    cntClk = 1'b1;
    repeat (6) @(negedge clk);

    finishRun();
  end
endmodule